// File: doc/BRIEF.md
# Secure-Aware Interrupt Acknowledge Unit

This block serves the acknowledge and end-of-interrupt side of one CPU interface in an interrupt controller. Each cycle it is offered the interrupt that currently wins arbitration, given as an ID, a priority byte and a group bit. It answers three kinds of access from the processor. An acknowledge read claims the interrupt. A highest-pending read only peeks at it. An end-of-interrupt write retires a claimed interrupt. Every access carries a secure attribute.

When interrupt groups are configured, the unit hides an interrupt from a security state that must not see it. A non-secure access to a group 0 interrupt sees the spurious ID 1023. A secure access to a group 1 interrupt sees ID 1022, unless the acknowledge-control input allows it. When the security extension is absent, every access counts as secure.

A successful acknowledge pulses an activate output, which the distributor uses to clear the pending bit and set the active bit. It also raises the running priority. Claimed interrupts are kept on a small active stack. The running priority is the priority at the top of that stack, or 0xFF when the stack is empty. An end-of-interrupt removes the matching entry and pulses a completion output, which the distributor uses to clear the active bit. A non-secure completion of a group 0 interrupt is dropped without any effect.

Top module: `sec_ack_unit`

## Requirements
- R1: After synchronous reset, `rd_valid`, `act_valid` and `done_valid` are 0 and `run_prio` is 0xFF.
- R2: With `cfg_groups`=1, `cfg_sec_ext`=1, `acc_secure`=0 and `pend_grp`=0 (group 0), an acknowledge or highest-pending read of a pending ID below 1020 returns 1023. Such an acknowledge activates nothing and leaves `run_prio` unchanged.
- R3: With `cfg_groups`=1, a secure access to a group 1 pending ID (`pend_grp`=1) below 1020 returns 1022 when `ack_ctl`=0. With `ack_ctl`=1 it returns the ID itself.
- R4: With `cfg_sec_ext`=0, `acc_secure` has no effect on reads or completions; every access behaves as secure.
- R5: With `cfg_groups`=0, there is no group filtering: a read returns the pending ID for either group and either security state.
- R6: An acknowledge whose filtered ID is 1020 or more returns that filtered ID unchanged, activates nothing and leaves `run_prio` unchanged.
- R7: An acknowledge of a visible ID whose `pend_prio` is equal to or above `run_prio` returns 1023 and changes no state.
- R8: A successful acknowledge returns the pending ID in `rd_id`. In the same cycle it pulses `act_valid` with `act_id` equal to that ID, and `run_prio` becomes `pend_prio`. All outputs are registered and appear one cycle after the access.
- R9: When DEPTH (4) interrupts are already active, a further acknowledge returns 1023 and changes no state.
- R10: An end-of-interrupt takes its ID from bits [9:0] of `eoi_data` only. When that ID is at the top of the stack, the unit pulses `done_valid` with `done_id` and restores `run_prio` to the next entry's priority, or to 0xFF when the stack becomes empty.
- R11: With `cfg_sec_ext`=1, a non-secure end-of-interrupt for an active group 0 interrupt is ignored: no `done_valid`, and the stack and `run_prio` are unchanged.
- R12: A secure end-of-interrupt for an active group 1 interrupt completes it even when `ack_ctl`=0.
- R13: An end-of-interrupt for an ID that is not active is ignored. An end-of-interrupt for an active ID below the top removes only that entry, and `run_prio` is unchanged.
- R14: A highest-pending read returns the filtered ID but never activates an interrupt or changes `run_prio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sec_ext | input | 1 | Security extension present |
| cfg_groups | input | 1 | Interrupt groups present |
| ack_ctl | input | 1 | Let secure accesses see group 1 interrupts |
| acc_op | input | 2 | Access: 0 none, 1 acknowledge read, 2 highest-pending read, 3 end-of-interrupt write |
| acc_secure | input | 1 | Secure attribute of the access |
| pend_id | input | 10 | Highest pending interrupt ID (1023 when none) |
| pend_prio | input | 8 | Priority of the pending interrupt (lower value is more urgent) |
| pend_grp | input | 1 | Group of the pending interrupt (1 = group 1) |
| eoi_data | input | 32 | End-of-interrupt write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_id | output | 10 | Returned interrupt ID |
| act_valid | output | 1 | Activate the acknowledged interrupt |
| act_id | output | 10 | ID to activate |
| done_valid | output | 1 | Completion pulse |
| done_id | output | 10 | ID completed |
| run_prio | output | 8 | Current running priority |

## Verification
The filter is tried with every combination of secure attribute, group bit, acknowledge-control, security extension and group configuration. This separates the 1023 hiding, the 1022 hiding and the pass-through. Acknowledges are tried at priorities above, equal to and below the running priority, and against a full stack, which tells the strict comparison and the depth limit apart. Completions target the top entry, an entry below the top, an ID that is not active, and a group 0 entry from a non-secure access, with junk in the upper data bits. These cases separate the pop, the middle removal, the ignore paths and the 10-bit decode. A long random run with a fixed seed then mixes all of these against a bench model of the stack.

// File: rtl/sec_ack_pkg.sv
package sec_ack_pkg;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;

    localparam logic [ID_W-1:0]   ID_SPURIOUS   = 10'd1023;
    localparam logic [ID_W-1:0]   ID_WRONG_GRP  = 10'd1022;
    localparam logic [ID_W-1:0]   ID_FIRST_SPEC = 10'd1020;
    localparam logic [PRIO_W-1:0] PRIO_IDLE     = '1;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ACK   = 2'd1,
        OP_HPEND = 2'd2,
        OP_EOI   = 2'd3
    } acc_op_t;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              grp;
        logic [PRIO_W-1:0] prio;
    } act_ent_t;

    function automatic logic is_special(input logic [ID_W-1:0] id);
        return id >= ID_FIRST_SPEC;
    endfunction
endpackage

// File: rtl/ack_id_filter.sv
module ack_id_filter
    import sec_ack_pkg::*;
(
    input  logic [ID_W-1:0] pend_id,
    input  logic            pend_grp,
    input  logic            eff_secure,
    input  logic            groups_on,
    input  logic            ack_ctl,
    output logic [ID_W-1:0] filt_id
);
    logic hide_g0;
    logic hide_g1;

    always_comb begin
        hide_g0 = groups_on && !pend_grp && !eff_secure;
        hide_g1 = groups_on && pend_grp && eff_secure && !ack_ctl;
        if (is_special(pend_id)) begin
            filt_id = pend_id;
        end else if (hide_g0) begin
            filt_id = ID_SPURIOUS;
        end else if (hide_g1) begin
            filt_id = ID_WRONG_GRP;
        end else begin
            filt_id = pend_id;
        end
    end
endmodule

// File: rtl/ack_active_stack.sv
module ack_active_stack
    import sec_ack_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  act_ent_t          push_ent,
    input  logic              rm,
    input  logic [$clog2(DEPTH)-1:0] rm_idx,
    input  logic [ID_W-1:0]   look_id,
    output logic              look_hit,
    output logic [$clog2(DEPTH)-1:0] look_idx,
    output logic              look_grp,
    output logic              full,
    output logic [PRIO_W-1:0] run_prio
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    act_ent_t         ent_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] top_idx;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
    assign run_prio = (cnt_q == '0) ? PRIO_IDLE : ent_q[top_idx].prio;

    // Highest matching slot wins, so the most recent claim of an ID is found.
    always_comb begin
        look_hit = 1'b0;
        look_idx = '0;
        look_grp = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (CNT_W'(j) < cnt_q && ent_q[j].id == look_id) begin
                look_hit = 1'b1;
                look_idx = IDX_W'(j);
                look_grp = ent_q[j].grp;
            end
        end
    end

    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        if (j < DEPTH - 1) begin : g_mid
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q[j] <= '0;
                end else if (push && cnt_q == CNT_W'(j)) begin
                    ent_q[j] <= push_ent;
                end else if (rm && IDX_W'(j) >= rm_idx) begin
                    ent_q[j] <= ent_q[j+1];
                end
            end
        end else begin : g_last
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q[j] <= '0;
                end else if (push && cnt_q == CNT_W'(j)) begin
                    ent_q[j] <= push_ent;
                end else if (rm && IDX_W'(j) >= rm_idx) begin
                    ent_q[j] <= '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push && !rm) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (rm && !push) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full); // R9
    AST_RM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        rm |-> (CNT_W'(rm_idx) < cnt_q)); // R13
    AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (rst)
        (rm && cnt_q == CNT_W'(1)) |=> run_prio == PRIO_IDLE); // R10
endmodule

// File: rtl/sec_ack_unit.sv
module sec_ack_unit
    import sec_ack_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_sec_ext,
    input  logic              cfg_groups,
    input  logic              ack_ctl,
    input  logic [1:0]        acc_op,
    input  logic              acc_secure,
    input  logic [ID_W-1:0]   pend_id,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              pend_grp,
    input  logic [31:0]       eoi_data,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_id,
    output logic              act_valid,
    output logic [ID_W-1:0]   act_id,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_id,
    output logic [PRIO_W-1:0] run_prio
);
    localparam int IDX_W = $clog2(DEPTH);

    acc_op_t          op;
    logic             eff_secure;
    logic [ID_W-1:0]  filt_id;
    logic             full;
    logic             look_hit;
    logic             look_grp;
    logic [IDX_W-1:0] look_idx;
    logic [ID_W-1:0]  eoi_id;
    logic             is_read;
    logic             ack_ok;
    logic             eoi_drop;
    logic             eoi_ok;
    logic [ID_W-1:0]  ret_id;
    act_ent_t         new_ent;

    assign op         = acc_op_t'(acc_op);
    assign eff_secure = !cfg_sec_ext || acc_secure;
    assign eoi_id     = eoi_data[ID_W-1:0];

    ack_id_filter u_filter (
        .pend_id    (pend_id),
        .pend_grp   (pend_grp),
        .eff_secure (eff_secure),
        .groups_on  (cfg_groups),
        .ack_ctl    (ack_ctl),
        .filt_id    (filt_id)
    );

    always_comb begin
        is_read  = (op == OP_ACK) || (op == OP_HPEND);
        ack_ok   = (op == OP_ACK) && !is_special(filt_id)
                   && (pend_prio < run_prio) && !full;
        eoi_drop = cfg_sec_ext && !acc_secure && !look_grp;
        eoi_ok   = (op == OP_EOI) && look_hit && !eoi_drop;
        if (op == OP_HPEND || is_special(filt_id)) begin
            ret_id = filt_id;
        end else if (ack_ok) begin
            ret_id = pend_id;
        end else begin
            ret_id = ID_SPURIOUS;
        end
        new_ent.id   = pend_id;
        new_ent.grp  = pend_grp;
        new_ent.prio = pend_prio;
    end

    ack_active_stack #(.DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (ack_ok),
        .push_ent (new_ent),
        .rm       (eoi_ok),
        .rm_idx   (look_idx),
        .look_id  (eoi_id),
        .look_hit (look_hit),
        .look_idx (look_idx),
        .look_grp (look_grp),
        .full     (full),
        .run_prio (run_prio)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid   <= 1'b0;
            rd_id      <= ID_SPURIOUS;
            act_valid  <= 1'b0;
            act_id     <= '0;
            done_valid <= 1'b0;
            done_id    <= '0;
        end else begin
            rd_valid   <= is_read;
            act_valid  <= ack_ok;
            done_valid <= eoi_ok;
            if (is_read) begin
                rd_id <= ret_id;
            end
            if (ack_ok) begin
                act_id <= pend_id;
            end
            if (eoi_ok) begin
                done_id <= eoi_id;
            end
        end
    end

    AST_ACK_RAISES_RUN: assert property (@(posedge clk) disable iff (rst)
        act_valid |-> (run_prio < $past(run_prio))); // R8
    AST_NS_HIDES_G0: assert property (@(posedge clk) disable iff (rst)
        (is_read && cfg_groups && cfg_sec_ext && !acc_secure && !pend_grp
         && !is_special(pend_id)) |=> (rd_id == ID_SPURIOUS && !act_valid)); // R2
    AST_LOW_PRIO_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ACK && !is_special(filt_id) && pend_prio >= run_prio)
        |=> (rd_id == ID_SPURIOUS && !act_valid && $stable(run_prio))); // R7
    AST_NS_EOI_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (op == OP_EOI && cfg_sec_ext && !acc_secure && look_hit && !look_grp)
        |=> (!done_valid && $stable(run_prio))); // R11
    AST_HPEND_NO_SIDE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HPEND) |=> (!act_valid && $stable(run_prio))); // R14
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act_valid, done_valid})); // R8
endmodule

// File: tb/sec_ack_unit_bench.sv
module sec_ack_unit_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_sec_ext = 1'b0;
    logic        cfg_groups = 1'b0;
    logic        ack_ctl = 1'b0;
    logic [1:0]  acc_op = 2'd0;
    logic        acc_secure = 1'b0;
    logic [9:0]  pend_id = 10'd0;
    logic [7:0]  pend_prio = 8'd0;
    logic        pend_grp = 1'b0;
    logic [31:0] eoi_data = 32'd0;
    logic        rd_valid, act_valid, done_valid;
    logic [9:0]  rd_id, act_id, done_id;
    logic [7:0]  run_prio;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // bench model of the active stack
    int m_id   [DEPTH];
    int m_grp  [DEPTH];
    int m_prio [DEPTH];
    int m_cnt = 0;

    always #5 clk = ~clk;

    sec_ack_unit #(.DEPTH(DEPTH)) u_sec_ack_unit (
        .clk(clk), .rst(rst), .cfg_sec_ext(cfg_sec_ext), .cfg_groups(cfg_groups),
        .ack_ctl(ack_ctl), .acc_op(acc_op), .acc_secure(acc_secure),
        .pend_id(pend_id), .pend_prio(pend_prio), .pend_grp(pend_grp),
        .eoi_data(eoi_data), .rd_valid(rd_valid), .rd_id(rd_id),
        .act_valid(act_valid), .act_id(act_id), .done_valid(done_valid),
        .done_id(done_id), .run_prio(run_prio)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model_run();
        return (m_cnt == 0) ? 255 : m_prio[m_cnt-1];
    endfunction

    function automatic int expect_filter(input int pid, input int pg, input int sec);
        int eff;
        eff = (!cfg_sec_ext || sec != 0) ? 1 : 0;
        if (pid >= 1020) return pid;
        if (cfg_groups && pg == 0 && eff == 0) return 1023;
        if (cfg_groups && pg == 1 && eff == 1 && !ack_ctl) return 1022;
        return pid;
    endfunction

    // Called at a negedge: drives one access, checks after the next posedge.
    task automatic step(input string req, input int op, input int sec, input int pid,
                        input int pp, input int pg, input logic [31:0] ed);
        int exp_rd, exp_act, exp_act_id, exp_done, exp_done_id, filt, hit, eid;
        exp_rd = -1; exp_act = 0; exp_act_id = -1; exp_done = 0; exp_done_id = -1;
        filt = expect_filter(pid, pg, sec);
        if (op == 1) begin
            if (filt >= 1020) exp_rd = filt;
            else if (pp >= model_run()) exp_rd = 1023;
            else if (m_cnt == DEPTH) exp_rd = 1023;
            else begin
                exp_rd = pid; exp_act = 1; exp_act_id = pid;
            end
        end else if (op == 2) begin
            exp_rd = filt;
        end else if (op == 3) begin
            eid = int'(ed[9:0]);
            hit = -1;
            for (int k = 0; k < m_cnt; k++) if (m_id[k] == eid) hit = k;
            if (hit >= 0 && !(cfg_sec_ext && sec == 0 && m_grp[hit] == 0)) begin
                exp_done = 1; exp_done_id = eid;
                for (int k = hit; k < m_cnt - 1; k++) begin
                    m_id[k] = m_id[k+1]; m_grp[k] = m_grp[k+1]; m_prio[k] = m_prio[k+1];
                end
                m_cnt--;
            end
        end
        if (exp_act == 1) begin
            m_id[m_cnt] = pid; m_grp[m_cnt] = pg; m_prio[m_cnt] = pp; m_cnt++;
        end
        acc_op = 2'(op); acc_secure = sec[0]; pend_id = 10'(pid);
        pend_prio = 8'(pp); pend_grp = pg[0]; eoi_data = ed;
        @(negedge clk);
        acc_op = 2'd0;
        check(req, "rd_valid", int'(rd_valid), (op == 1 || op == 2) ? 1 : 0);
        if (exp_rd >= 0) check(req, "rd_id", int'(rd_id), exp_rd);
        check(req, "act_valid", int'(act_valid), exp_act);
        if (exp_act == 1) check(req, "act_id", int'(act_id), exp_act_id);
        check(req, "done_valid", int'(done_valid), exp_done);
        if (exp_done == 1) check(req, "done_id", int'(done_id), exp_done_id);
        check(req, "run_prio", int'(run_prio), model_run());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EC0_ACC5);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "rd_valid", int'(rd_valid), 0);
        check("R1", "act_valid", int'(act_valid), 0);
        check("R1", "done_valid", int'(done_valid), 0);
        check("R1", "run_prio", int'(run_prio), 255);

        cfg_sec_ext = 1; cfg_groups = 1; ack_ctl = 0;
        step("R14", 2, 1, 5, 8'h30, 0, 0);          // secure peek at group 0
        step("R2", 2, 0, 5, 8'h30, 0, 0);           // NS peek hidden
        step("R2", 1, 0, 5, 8'h30, 0, 0);           // NS ack hidden, no state
        step("R3", 1, 1, 6, 8'h30, 1, 0);           // group 1 from secure -> 1022
        ack_ctl = 1;
        step("R3", 2, 1, 6, 8'h30, 1, 0);           // now visible
        step("R6", 1, 1, 1021, 8'h10, 0, 0);        // special passes through
        step("R8", 1, 1, 7, 8'h40, 0, 0);
        step("R7", 1, 1, 8, 8'h40, 0, 0);           // equal priority refused
        step("R7", 1, 1, 8, 8'h50, 0, 0);
        step("R8", 1, 1, 9, 8'h20, 1, 0);
        step("R8", 1, 1, 10, 8'h10, 0, 0);
        step("R8", 1, 1, 11, 8'h08, 0, 0);
        step("R9", 1, 1, 12, 8'h01, 0, 0);          // stack full
        step("R11", 3, 0, 0, 0, 0, 32'd10);         // NS EOI of group 0
        step("R13", 3, 1, 0, 0, 0, 32'd99);         // not active
        ack_ctl = 0;
        step("R12", 3, 1, 0, 0, 0, 32'd9);          // group 1, below top
        step("R13", 2, 1, 0, 0, 0, 0);              // run_prio kept
        step("R10", 3, 1, 0, 0, 0, 32'hABCD_F400 | 32'd11); // upper junk
        step("R11", 3, 0, 0, 0, 0, 32'd10);
        step("R10", 3, 1, 0, 0, 0, 32'd10);
        step("R10", 3, 1, 0, 0, 0, 32'hFFFF_FC07);  // id 7, empties
        cfg_sec_ext = 0;
        step("R4", 1, 0, 20, 8'h60, 0, 0);          // NS attribute ignored
        step("R4", 2, 0, 21, 8'h30, 1, 0);          // group 1 seen as secure -> 1022
        step("R4", 3, 0, 0, 0, 0, 32'd20);          // completes
        cfg_groups = 0;
        step("R5", 2, 1, 22, 8'h30, 1, 0);
        step("R5", 2, 0, 23, 8'h30, 0, 0);
        step("R5", 1, 0, 23, 8'h30, 1, 0);
        step("R10", 3, 1, 0, 0, 0, 32'd23);

        for (int it = 0; it < 3000; it++) begin
            int op, sec, pid, pp, pg, r;
            logic [31:0] ed;
            if (it % 64 == 0) begin
                cfg_sec_ext = 1'($urandom);
                cfg_groups  = 1'($urandom);
            end
            if (it % 16 == 0) ack_ctl = 1'($urandom);
            op  = int'($urandom_range(1, 3));
            sec = int'($urandom_range(0, 1));
            pg  = int'($urandom_range(0, 1));
            r   = int'($urandom_range(0, 9));
            pid = (r == 0) ? int'($urandom_range(1020, 1023)) : int'($urandom_range(0, 31));
            pp  = int'($urandom_range(0, 255));
            ed  = $urandom;
            if (m_cnt > 0 && $urandom_range(0, 3) != 0)
                ed[9:0] = 10'(m_id[$urandom_range(0, m_cnt - 1)]);
            else
                ed[9:0] = 10'($urandom_range(0, 40));
            step("R8/R10 random", op, sec, pid, pp, pg, ed);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule